// File: doc/BRIEF.md
# Multi-Channel Prescaled PWM Bank

The block is a bank of up to eight pulse-width modulators behind a plain 32-bit word-addressed register bus. A control register carries one run bit per channel. Every channel owns two registers. The edge register gives the count at which the pin enters its active phase and the count at which it leaves it. The timing register gives the period count, a 2-bit drive code for each phase and a 3-bit prescaler select. Each channel counts prescaled ticks of the shared clock and drives one pin, together with an output enable for that pin.

Each register can be reached at four word addresses. The base address replaces the register. The other three set, clear or toggle the bits written to them. Software can therefore start and stop one channel without a read-modify-write. New edge or timing values wait for the next period wrap before they reach a running channel, so no period is ever produced with a mix of old and new settings.

Top module: `pwm_bank`

## Requirements
- R1: After synchronous reset, every register reads 0 and every `pwm_out` and `pwm_oe` bit is 0.
- R2: The word address is split into a register index (`addr[ADDR_W-1:2]`) and an access mode (`addr[1:0]`). Index 0 is the control register. Index 1+2n is channel n's edge register and index 2+2n is its timing register. `rd_data` holds the value addressed one cycle after `rd_en` is high. An index beyond the last register reads 0, and a write to it changes nothing.
- R3: Access mode 0 replaces the register with `wr_data`. Mode 1 ORs `wr_data` in, mode 2 clears the bits set in `wr_data`, and mode 3 XORs them. A read at any mode address returns the register's current value.
- R4: Reserved bits read 0. These are the control bits at and above NCH and timing bits 31:23. All 32 edge bits are stored.
- R5: The channel counter advances once per prescaler tick. Having reached the period count P (timing bits 15:0), it wraps to 0, so a period lasts P+1 ticks.
- R6: Edge register bits 15:0 hold the start edge S and bits 31:16 hold the end edge E. The channel is in its active phase while S <= count < E, and in its inactive phase otherwise.
- R7: The active-phase drive code is in timing bits 17:16 and the inactive-phase code is in bits 19:18. Code 3 drives the pin high with the enable set. Code 2 drives it low with the enable set. Codes 0 and 1 clear the enable and drive 0.
- R8: Prescaler select codes 0 to 7 (timing bits 22:20) divide the clock by 1, 2, 4, 8, 16, 64, 256 and 1024.
- R9: A channel whose control bit is 0 holds its counter and prescaler at 0 and drives `pwm_out`=0 and `pwm_oe`=0. On enable, counting starts at 0 with a full prescaler interval.
- R10: Edge and timing writes to a running channel take effect when its counter wraps to 0. While the channel is disabled, the values present at enable are the ones used.
- R11: Channels run independently: each follows only its own registers and control bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Shared clock, also the prescaler source |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | ADDR_W | Word address: register index and access mode |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 32 | Registered read data |
| pwm_out | output | NCH | Pin level per channel |
| pwm_oe | output | NCH | Pin output enable per channel |

## Verification
The assertions check, on every cycle, that the counter never passes the latched period count. They also check that the prescaler phase stays below the selected divide, that a disabled channel keeps its counter at 0 and its enable low, and that the latched settings do not change in the middle of a period. Set and clear writes to the control register, and reads of unmapped indices, are checked at the cycle after the access. Only the bench scenarios can show the exact pulse shapes: duty counts over whole periods, each entry of the divide table and each drive code on the pins. They also show that a write made mid-period appears only after the wrap, and that two channels running at once with different settings do not disturb each other.

// File: rtl/pwm_bank_pkg.sv
package pwm_bank_pkg;

    localparam int DATA_W = 32;
    localparam int CNT_W  = 16;
    localparam int PRE_W  = 10;

    localparam logic [DATA_W-1:0] TIMING_MASK = 32'h007F_FFFF;

    typedef enum logic [1:0] {
        OP_WRITE = 2'd0,
        OP_SET   = 2'd1,
        OP_CLR   = 2'd2,
        OP_TOG   = 2'd3
    } alias_op_e;

    typedef struct packed {
        logic [CNT_W-1:0] stop_edge;
        logic [CNT_W-1:0] start_edge;
    } edges_t;

    typedef struct packed {
        logic [8:0]       rsvd;
        logic [2:0]       div_sel;
        logic [1:0]       idle_lvl;
        logic [1:0]       busy_lvl;
        logic [CNT_W-1:0] period;
    } timing_t;

    typedef struct packed {
        logic drive;
        logic level;
    } pin_t;

    function automatic logic [DATA_W-1:0] apply_op(alias_op_e op,
                                                   logic [DATA_W-1:0] old,
                                                   logic [DATA_W-1:0] wdata);
        case (op)
            OP_SET:  return old | wdata;
            OP_CLR:  return old & ~wdata;
            OP_TOG:  return old ^ wdata;
            default: return wdata;
        endcase
    endfunction

    function automatic logic [PRE_W-1:0] div_limit(logic [2:0] sel);
        int unsigned sh;
        logic [PRE_W:0] full;
        sh   = (sel < 3'd5) ? int'(sel) : (2 * int'(sel) - 4);
        full = (PRE_W+1)'(1) << sh;
        return PRE_W'(full - 1'b1);
    endfunction

    function automatic pin_t level_decode(logic [1:0] code);
        pin_t p;
        p.drive = code[1];
        p.level = code[1] & code[0];
        return p;
    endfunction

endpackage

// File: rtl/pwm_bank_regs.sv
module pwm_bank_regs
    import pwm_bank_pkg::*;
#(
    parameter int NCH    = 8,
    parameter int ADDR_W = 7
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [ADDR_W-1:0]      addr,
    input  logic                   wr_en,
    input  logic [DATA_W-1:0]      wr_data,
    input  logic                   rd_en,
    output logic [DATA_W-1:0]      rd_data,
    output logic [NCH-1:0]         run,
    output edges_t  [NCH-1:0]      edges,
    output timing_t [NCH-1:0]      timing
);
    localparam int IDX_W = ADDR_W - 2;
    localparam int NREG  = 1 + 2 * NCH;
    localparam logic [DATA_W-1:0] CTRL_MASK =
        (NCH >= DATA_W) ? '1 : ((DATA_W'(1) << NCH) - 1'b1);

    logic [IDX_W-1:0]  idx;
    alias_op_e         op;
    logic [DATA_W-1:0] ctrl_q;
    logic [DATA_W-1:0] edge_q [NCH];
    logic [DATA_W-1:0] time_q [NCH];
    logic [DATA_W-1:0] rd_mux;

    assign idx = addr[ADDR_W-1:2];
    assign op  = alias_op_e'(addr[1:0]);
    assign run = ctrl_q[NCH-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
        end else if (wr_en && idx == '0) begin
            ctrl_q <= apply_op(op, ctrl_q, wr_data) & CTRL_MASK;
        end
    end

    for (genvar n = 0; n < NCH; n++) begin : g_bank
        always_ff @(posedge clk) begin
            if (rst) begin
                edge_q[n] <= '0;
                time_q[n] <= '0;
            end else if (wr_en) begin
                if (idx == IDX_W'(1 + 2 * n))
                    edge_q[n] <= apply_op(op, edge_q[n], wr_data);
                if (idx == IDX_W'(2 + 2 * n))
                    time_q[n] <= apply_op(op, time_q[n], wr_data) & TIMING_MASK;
            end
        end
        assign edges[n]  = edges_t'(edge_q[n]);
        assign timing[n] = timing_t'(time_q[n]);
    end

    always_comb begin
        rd_mux = '0;
        if (idx == '0) rd_mux = ctrl_q;
        for (int n = 0; n < NCH; n++) begin
            if (idx == IDX_W'(1 + 2 * n)) rd_mux = edge_q[n];
            if (idx == IDX_W'(2 + 2 * n)) rd_mux = time_q[n];
        end
    end

    always_ff @(posedge clk) begin
        if (rst)        rd_data <= '0;
        else if (rd_en) rd_data <= rd_mux;
    end

    // R3
    ctrl_set_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && idx == '0 && op == OP_SET) |=>
        ((ctrl_q & $past(wr_data & CTRL_MASK)) == $past(wr_data & CTRL_MASK)));

    // R3
    ctrl_clr_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && idx == '0 && op == OP_CLR) |=>
        ((ctrl_q & $past(wr_data)) == '0));

    // R2
    unmapped_read_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_en && int'(idx) >= NREG) |=> (rd_data == '0));

endmodule

// File: rtl/pwm_bank_prescaler.sv
module pwm_bank_prescaler
    import pwm_bank_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [PRE_W-1:0] limit,
    output logic             tick
);
    logic [PRE_W-1:0] phase_q;

    assign tick = run && (phase_q >= limit);

    always_ff @(posedge clk) begin
        if (rst || !run)  phase_q <= '0;
        else if (tick)    phase_q <= '0;
        else              phase_q <= phase_q + 1'b1;
    end

    // R8
    phase_range_chk: assert property (@(posedge clk) disable iff (rst)
        phase_q <= limit);

endmodule

// File: rtl/pwm_bank_channel.sv
module pwm_bank_channel
    import pwm_bank_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    run,
    input  edges_t  edges_reg,
    input  timing_t timing_reg,
    output logic    pin_out,
    output logic    pin_oe
);
    edges_t           work_e;
    timing_t          work_t;
    logic [CNT_W-1:0] cnt_q;
    logic             tick;
    logic             wrap;
    logic             busy;
    pin_t             pin;

    pwm_bank_prescaler i_pre (
        .clk   (clk),
        .rst   (rst),
        .run   (run),
        .limit (div_limit(work_t.div_sel)),
        .tick  (tick)
    );

    assign wrap = tick && (cnt_q == work_t.period);

    always_ff @(posedge clk) begin
        if (rst) begin
            work_e <= '0;
            work_t <= '0;
        end else if (!run || wrap) begin
            work_e <= edges_reg;
            work_t <= timing_reg;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || !run) cnt_q <= '0;
        else if (wrap)   cnt_q <= '0;
        else if (tick)   cnt_q <= cnt_q + 1'b1;
    end

    assign busy = (cnt_q >= work_e.start_edge) && (cnt_q < work_e.stop_edge);

    always_comb begin
        pin = level_decode(busy ? work_t.busy_lvl : work_t.idle_lvl);
        if (!run) pin = '0;
    end

    assign pin_out = pin.level;
    assign pin_oe  = pin.drive;

    // R5
    cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= work_t.period);

    // R9
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !run |=> (cnt_q == '0 || run));

    // R9
    idle_oe_chk: assert property (@(posedge clk) disable iff (rst)
        pin_oe |-> run);

    // R10
    work_stable_chk: assert property (@(posedge clk) disable iff (rst)
        (run && cnt_q != '0) |-> ($stable(work_e) && $stable(work_t)));

    // R4
    rsvd_zero_chk: assert property (@(posedge clk) disable iff (rst)
        timing_reg.rsvd == '0);

endmodule

// File: rtl/pwm_bank.sv
module pwm_bank
    import pwm_bank_pkg::*;
#(
    parameter int NCH    = 8,
    parameter int ADDR_W = 7
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic [31:0]       wr_data,
    input  logic              rd_en,
    output logic [31:0]       rd_data,
    output logic [NCH-1:0]    pwm_out,
    output logic [NCH-1:0]    pwm_oe
);
    logic [NCH-1:0]      run;
    edges_t  [NCH-1:0]   edges;
    timing_t [NCH-1:0]   timing;

    initial begin
        addr_width_chk: assert ((1 << (ADDR_W - 2)) >= 1 + 2 * NCH);
    end

    pwm_bank_regs #(.NCH(NCH), .ADDR_W(ADDR_W)) i_regs (
        .clk     (clk),
        .rst     (rst),
        .addr    (addr),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .rd_en   (rd_en),
        .rd_data (rd_data),
        .run     (run),
        .edges   (edges),
        .timing  (timing)
    );

    for (genvar n = 0; n < NCH; n++) begin : g_ch
        pwm_bank_channel i_ch (
            .clk        (clk),
            .rst        (rst),
            .run        (run[n]),
            .edges_reg  (edges[n]),
            .timing_reg (timing[n]),
            .pin_out    (pwm_out[n]),
            .pin_oe     (pwm_oe[n])
        );
    end

endmodule

// File: tb/test_pwm_bank.sv
module test_pwm_bank;
    localparam int NCH    = 8;
    localparam int ADDR_W = 7;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [ADDR_W-1:0] addr = '0;
    logic              wr_en = 1'b0;
    logic [31:0]       wr_data = '0;
    logic              rd_en = 1'b0;
    logic [31:0]       rd_data;
    logic [NCH-1:0]    pwm_out;
    logic [NCH-1:0]    pwm_oe;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    pwm_bank #(.NCH(NCH), .ADDR_W(ADDR_W)) i_pwm_bank (
        .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
        .rd_en(rd_en), .rd_data(rd_data), .pwm_out(pwm_out), .pwm_oe(pwm_oe)
    );

    function automatic logic [ADDR_W-1:0] a_ctrl(int op);
        return ADDR_W'(op);
    endfunction
    function automatic logic [ADDR_W-1:0] a_edge(int ch, int op);
        return ADDR_W'((1 + 2 * ch) * 4 + op);
    endfunction
    function automatic logic [ADDR_W-1:0] a_time(int ch, int op);
        return ADDR_W'((2 + 2 * ch) * 4 + op);
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(logic [ADDR_W-1:0] a, logic [31:0] d);
        addr = a; wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(logic [ADDR_W-1:0] a, output logic [31:0] d);
        addr = a; rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        d = rd_data;
    endtask

    task automatic measure(int ch, int n, output int hi, output int oe);
        hi = 0; oe = 0;
        for (int i = 0; i < n; i++) begin
            if (pwm_out[ch]) hi++;
            if (pwm_oe[ch])  oe++;
            @(negedge clk);
        end
    endtask

    function automatic logic [31:0] tword(int per, int busy, int idle, int dv);
        return 32'(per) | (32'(busy) << 16) | (32'(idle) << 18) | (32'(dv) << 20);
    endfunction

    task automatic t_reset;
        logic [31:0] d;
        chk("R1 out", 32'(pwm_out), 0);
        chk("R1 oe", 32'(pwm_oe), 0);
        rd(a_ctrl(0), d);   chk("R1 ctrl", d, 0);
        rd(a_time(3, 0), d); chk("R1 timing3", d, 0);
    endtask

    task automatic t_alias;
        logic [31:0] d;
        wr(a_ctrl(1), 32'h5);
        rd(a_ctrl(0), d); chk("R3 set", d, 32'h5);
        wr(a_ctrl(2), 32'h1);
        rd(a_ctrl(0), d); chk("R3 clear", d, 32'h4);
        wr(a_ctrl(3), 32'h6);
        rd(a_ctrl(3), d); chk("R3 toggle", d, 32'h2);
        wr(a_ctrl(0), 32'h0);
        wr(a_time(1, 0), 32'h0001_0005);
        wr(a_time(1, 1), 32'h0002_0000);
        rd(a_time(1, 2), d); chk("R3 timing set", d, 32'h0003_0005);
        wr(a_time(1, 2), 32'h1);
        rd(a_time(1, 0), d); chk("R3 timing clear", d, 32'h0003_0004);
        wr(a_time(1, 0), 32'h0);
    endtask

    task automatic t_reserved;
        logic [31:0] d;
        wr(a_time(2, 0), 32'hFFFF_FFFF);
        rd(a_time(2, 0), d); chk("R4 timing mask", d, 32'h007F_FFFF);
        wr(a_edge(2, 0), 32'hFFFF_FFFF);
        rd(a_edge(2, 1), d); chk("R4 edge full", d, 32'hFFFF_FFFF);
        wr(a_ctrl(0), 32'hFFFF_FFFF);
        rd(a_ctrl(0), d); chk("R4 ctrl mask", d, 32'h0000_00FF);
        wr(a_ctrl(0), 0);
        wr(ADDR_W'(17 * 4), 32'h1234_5678);
        rd(ADDR_W'(17 * 4), d); chk("R2 unmapped", d, 0);
        rd(a_edge(2, 0), d);    chk("R2 edge2 intact", d, 32'hFFFF_FFFF);
        wr(a_time(2, 0), 0);
        wr(a_edge(2, 0), 0);
    endtask

    task automatic t_duty;
        int hi, oe;
        bit ok;
        wr(a_edge(0, 0), 32'h0003_0000);
        wr(a_time(0, 0), tword(9, 3, 2, 0));
        wr(a_ctrl(0), 32'h1);
        ok = 1;
        for (int k = 0; k < 10; k++) begin
            if (pwm_out[0] !== (k < 3)) ok = 0;
            @(negedge clk);
        end
        chk("R6 phase shape", 32'(ok), 1);
        measure(0, 40, hi, oe);
        chk("R5 duty 3/10", 32'(hi), 12);
        chk("R7 oe codes 3/2", 32'(oe), 40);
        wr(a_ctrl(0), 0);
        wr(a_edge(0, 0), 32'h0006_0002);
        wr(a_ctrl(0), 32'h1);
        measure(0, 50, hi, oe);
        chk("R6 start edge 2..5", 32'(hi), 20);
        wr(a_ctrl(0), 0);
    endtask

    task automatic t_levels;
        int hi, oe;
        wr(a_edge(0, 0), 32'h0003_0000);
        wr(a_time(0, 0), tword(9, 0, 3, 0));
        wr(a_ctrl(0), 32'h1);
        measure(0, 30, hi, oe);
        chk("R7 idle high", 32'(hi), 21);
        chk("R7 busy code0 hiz", 32'(oe), 21);
        wr(a_ctrl(0), 0);
        wr(a_time(0, 0), tword(9, 1, 2, 0));
        wr(a_ctrl(0), 32'h1);
        measure(0, 30, hi, oe);
        chk("R7 code1 hiz, code2 low", 32'(hi), 0);
        chk("R7 code1 oe", 32'(oe), 21);
        wr(a_ctrl(0), 0);
    endtask

    task automatic t_prescale;
        int hi, oe, dv;
        for (int c = 0; c < 8; c++) begin
            case (c)
                0: dv = 1;    1: dv = 2;   2: dv = 4;   3: dv = 8;
                4: dv = 16;   5: dv = 64;  6: dv = 256; default: dv = 1024;
            endcase
            wr(a_edge(0, 0), 32'h0001_0000);
            wr(a_time(0, 0), tword(1, 3, 2, c));
            wr(a_ctrl(0), 32'h1);
            measure(0, 4 * dv, hi, oe);
            chk($sformatf("R8 divide code %0d", c), 32'(hi), 32'(2 * dv));
            wr(a_ctrl(0), 0);
        end
    endtask

    task automatic t_disable;
        int hi, oe;
        wr(a_edge(0, 0), 32'h0003_0000);
        wr(a_time(0, 0), tword(9, 3, 2, 0));
        wr(a_ctrl(0), 32'h1);
        measure(0, 5, hi, oe);
        wr(a_ctrl(0), 0);
        measure(0, 20, hi, oe);
        chk("R9 disabled out", 32'(hi), 0);
        chk("R9 disabled oe", 32'(oe), 0);
        wr(a_ctrl(0), 32'h1);
        measure(0, 10, hi, oe);
        chk("R9 restart from zero", 32'(hi), 3);
        wr(a_ctrl(0), 0);
    endtask

    task automatic t_boundary;
        bit ok;
        wr(a_edge(0, 0), 32'h0003_0000);
        wr(a_time(0, 0), tword(9, 3, 2, 0));
        wr(a_ctrl(0), 32'h1);
        wr(a_edge(0, 0), 32'h0007_0000);
        ok = 1;
        for (int k = 1; k < 20; k++) begin
            if (pwm_out[0] !== ((k < 3) || (k >= 10 && k < 17))) ok = 0;
            @(negedge clk);
        end
        chk("R10 update at wrap", 32'(ok), 1);
        wr(a_ctrl(0), 0);
    endtask

    task automatic t_multi;
        int h0, o0, h2, o2;
        bit ok;
        wr(a_edge(0, 0), 32'h0003_0000);
        wr(a_time(0, 0), tword(9, 3, 2, 0));
        wr(a_edge(2, 0), 32'h0004_0000);
        wr(a_time(2, 0), tword(4, 3, 2, 1));
        wr(a_ctrl(0), 32'h5);
        h0 = 0; h2 = 0; ok = 1;
        for (int i = 0; i < 40; i++) begin
            if (pwm_out[0]) h0++;
            if (pwm_out[2]) h2++;
            if (pwm_oe[1])  ok = 0;
            @(negedge clk);
        end
        chk("R11 ch0 duty", 32'(h0), 12);
        chk("R11 ch2 duty", 32'(h2), 32);
        chk("R11 ch1 idle", 32'(ok), 1);
        wr(a_ctrl(2), 32'h1);
        measure(2, 20, h2, o2);
        measure(0, 10, h0, o0);
        chk("R11 ch0 off after clear", 32'(o0), 0);
        chk("R11 ch2 still running", 32'(o2), 20);
        wr(a_ctrl(0), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset;
        t_alias;
        t_reserved;
        t_duty;
        t_levels;
        t_prescale;
        t_disable;
        t_boundary;
        t_multi;
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule